// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a synthesizable model of a 2048-bit serial nonvolatile memory that is reached over a Microwire-style link made of chip select, serial clock, a data-in line and a data-out line. The storage sits in on-chip flip-flops. An organization input picks either 128 sixteen-bit words or 256 bytes. A host frames each command as a start bit, a two-bit opcode and an address. The block decodes seven commands: read, write, erase, erase-all, write-all, write-enable and write-disable. All activity runs in one system clock domain, and the serial clock is oversampled by that clock.

Programming commands start a self-timed internal cycle of a fixed number of system clocks. While chip select is high, the data-out pin then reports that cycle's progress. Data-out is high-impedance at all other times except while read data is being shifted out. The output enable is a separate port, so a bench can join data-in and data-out into a single wire.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every location reads as all ones, writes are locked, and `do_oe` is low even when `cs` is high.
- R2: A command starts with the first 1 sampled on `di` at a rising `sk` while `cs` is high, and any 0s before it are ignored. Two opcode bits follow, MSB first. The address comes next, MSB first. It is 7+EXTRA_ABIT bits in x16 mode and 8+EXTRA_ABIT bits in x8 mode, and any bits above the word or byte index are don't-care.
- R3: Opcode 10 is read. After the last address bit `do_oe` goes high and `do_o` gives a 0. The next rising `sk` edges then give the data MSB first, 16 bits in x16 mode or 8 bits in x8 mode. The rising edge after the last data bit returns `do_o` to high-impedance.
- R4: Write, erase, erase-all and write-all have no effect until write-enable is issued. Write-enable is opcode 00 with the top two address bits 11. Write-disable is opcode 00 with top bits 00, and it locks them again.
- R5: Opcode 01 takes one data word or byte after the address, MSB first. The falling `cs` after the last data bit starts the internal cycle, and the location takes the data when that cycle ends.
- R6: Opcode 11 sets the addressed word or byte to all ones.
- R7: Opcode 00 with top address bits 10 sets every location to all ones. Opcode 00 with top bits 01 takes one data word or byte and writes it to every location. In x8 mode that is every byte.
- R8: In x8 mode, byte address b lies in word b/2. An even b selects bits 7:0 of that word and an odd b selects bits 15:8. The other byte of the word is left unchanged.
- R9: After an internal cycle starts, raising `cs` makes `do_oe` high with `do_o` low while the cycle runs. `do_o` goes high once the cycle ends, which is WRITE_CYCLES system clocks after it started.
- R10: While `do_o` is reporting status under `cs` high, a 1 on `di` at a rising `sk` returns `do_o` to high-impedance. This holds whether the cycle is still running or has ended.
- R11: A low `cs` aborts any partly shifted command. A write cut short before its last data bit changes no location and starts no cycle, so no status is reported afterwards.
- R12: `do_oe` is low whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on its rising edge |
| di | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial data or ready/busy output |
| do_oe | output | 1 | Output enable for do_o; low means high-impedance |

## Verification
The hardest state to reach is status release while the internal cycle is still running. To get there, a host must complete a programming command, drop and raise chip select, and then shift a 1 within WRITE_CYCLES clocks. The bench does exactly that, and then waits out the cycle before reading the location back, so that it can tell the release apart from a ready flag. Partial-write aborts and locked writes are driven as directed cases. Random command sequences in both organizations are then checked against a bench model of the array.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_ARMED,
        ST_DONE
    } mw_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_FILL_ONES,
        OP_FILL_DATA
    } mw_prog_e;

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_fall
);
    typedef struct packed {
        logic sk;
        logic cs;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d.sk = sk;
        d.cs = cs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sk_rise = sk & ~q.sk;
    assign cs_fall = q.cs & ~cs;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic hit;
        assign hit      = wr_en && (wr_all || (wr_idx == IDX_W'(i)));
        assign mem_d[i] = hit ? ((mem_q[i] & ~wr_mask) | (wr_data & wr_mask))
                              : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int WORDS        = 128,
    parameter int EXTRA_ABIT   = 1,
    parameter int WRITE_CYCLES = 40,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int HALF   = DATA_W / 2,
    localparam int AW16   = IDX_W + EXTRA_ABIT,
    localparam int AW8    = AW16 + 1,
    localparam int BITS_W = $clog2(DATA_W + AW8 + 1),
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org_x16,
    input  logic              cs,
    input  logic              di,
    input  logic              sk_rise,
    input  logic              cs_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              mem_we,
    output logic              mem_all,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] mem_mask,
    output logic              do_o,
    output logic              do_oe,
    output logic              busy_o,
    output logic              wen_o,
    output logic              stat_o,
    output logic              rdoe_o,
    output mw_state_e         st_o,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        mw_state_e          st;
        mw_prog_e           op;
        logic [1:0]         opc;
        logic [AW8-1:0]     addr;
        logic [DATA_W-1:0]  sh;
        logic [BITS_W-1:0]  nbit;
        logic               wen;
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic               stat;
        logic               rd_oe;
        logic               dout;
    } ctrl_t;

    ctrl_t q, d;

    logic [BITS_W-1:0] dw, aw;
    logic [AW8-1:0]    a_nx;
    logic [1:0]        top2;
    logic [DATA_W-1:0] rd_load;
    logic [DATA_W-1:0] wdata_rep;

    assign dw        = org_x16 ? BITS_W'(DATA_W) : BITS_W'(HALF);
    assign aw        = org_x16 ? BITS_W'(AW16) : BITS_W'(AW8);
    assign a_nx      = {q.addr[AW8-2:0], di};
    assign top2      = 2'(a_nx >> (aw - BITS_W'(2)));
    assign rd_idx    = org_x16 ? a_nx[IDX_W-1:0] : a_nx[IDX_W:1];
    assign rd_load   = org_x16 ? rd_data
                     : {(a_nx[0] ? rd_data[DATA_W-1:HALF] : rd_data[HALF-1:0]),
                        {HALF{1'b0}}};
    assign wdata_rep = org_x16 ? q.sh : {q.sh[HALF-1:0], q.sh[HALF-1:0]};

    // commit path: the internal cycle applies its operation on its final clock
    always_comb begin
        mem_we   = q.busy && (q.cnt == '0);
        mem_all  = (q.op == OP_FILL_ONES) || (q.op == OP_FILL_DATA);
        mem_idx  = org_x16 ? q.addr[IDX_W-1:0] : q.addr[IDX_W:1];
        mem_data = ((q.op == OP_WRITE) || (q.op == OP_FILL_DATA)) ? wdata_rep : '1;
        if (mem_all || org_x16) mem_mask = '1;
        else if (q.addr[0])     mem_mask = {{HALF{1'b1}}, {HALF{1'b0}}};
        else                    mem_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
    end

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - 1'b1;
        end
        if (!cs) begin
            d.st    = ST_IDLE;
            d.rd_oe = 1'b0;
            d.nbit  = '0;
            if (cs_fall && (q.st == ST_ARMED) && !q.busy) begin
                d.busy = 1'b1;
                d.cnt  = CNT_W'(WRITE_CYCLES - 1);
                d.stat = 1'b1;
            end
        end else if (sk_rise) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (di) begin
                        d.stat = 1'b0;
                        if (!q.busy) begin
                            d.st   = ST_OPC;
                            d.nbit = '0;
                        end
                    end
                end
                ST_OPC: begin
                    d.opc  = {q.opc[0], di};
                    d.nbit = q.nbit + 1'b1;
                    if (q.nbit == BITS_W'(1)) begin
                        d.st   = ST_ADDR;
                        d.nbit = '0;
                        d.addr = '0;
                    end
                end
                ST_ADDR: begin
                    d.addr = a_nx;
                    d.nbit = q.nbit + 1'b1;
                    if (q.nbit == aw - 1'b1) begin
                        d.nbit = '0;
                        d.sh   = '0;
                        d.st   = ST_DONE;
                        unique case (q.opc)
                            2'b10: begin
                                d.st    = ST_RDATA;
                                d.sh    = rd_load;
                                d.rd_oe = 1'b1;
                                d.dout  = 1'b0;
                                d.nbit  = dw;
                            end
                            2'b01: begin
                                d.op = OP_WRITE;
                                d.st = ST_WDATA;
                            end
                            2'b11: begin
                                d.op = OP_ERASE;
                                d.st = q.wen ? ST_ARMED : ST_DONE;
                            end
                            default: begin
                                unique case (top2)
                                    2'b11: d.wen = 1'b1;
                                    2'b00: d.wen = 1'b0;
                                    2'b10: begin
                                        d.op = OP_FILL_ONES;
                                        d.st = q.wen ? ST_ARMED : ST_DONE;
                                    end
                                    default: begin
                                        d.op = OP_FILL_DATA;
                                        d.st = ST_WDATA;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (q.nbit == '0) begin
                        d.rd_oe = 1'b0;
                        d.st    = ST_DONE;
                    end else begin
                        d.dout = q.sh[DATA_W-1];
                        d.sh   = q.sh << 1;
                        d.nbit = q.nbit - 1'b1;
                    end
                end
                ST_WDATA: begin
                    d.sh   = {q.sh[DATA_W-2:0], di};
                    d.nbit = q.nbit + 1'b1;
                    if (q.nbit == dw - 1'b1) d.st = q.wen ? ST_ARMED : ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.op <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign do_oe  = cs & (q.rd_oe | q.stat);
    assign do_o   = do_oe & (q.rd_oe ? q.dout : ~q.busy);
    assign busy_o = q.busy;
    assign wen_o  = q.wen;
    assign stat_o = q.stat;
    assign rdoe_o = q.rd_oe;
    assign st_o   = q.st;
    assign cnt_o  = q.cnt;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int WORDS        = 128,
    parameter int EXTRA_ABIT   = 1,
    parameter int WRITE_CYCLES = 40,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_x16,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    logic              sk_rise, cs_fall;
    logic [IDX_W-1:0]  rd_idx, mem_idx;
    logic [DATA_W-1:0] rd_data, mem_data, mem_mask;
    logic              mem_we, mem_all;
    logic              busy_w, wen_w, stat_w, rdoe_w;
    mw_state_e         st_w;
    logic [CNT_W-1:0]  cnt_w;

    mw_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .cs      (cs),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    mw_ctrl #(
        .DATA_W       (DATA_W),
        .WORDS        (WORDS),
        .EXTRA_ABIT   (EXTRA_ABIT),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .org_x16  (org_x16),
        .cs       (cs),
        .di       (di),
        .sk_rise  (sk_rise),
        .cs_fall  (cs_fall),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .mem_we   (mem_we),
        .mem_all  (mem_all),
        .mem_idx  (mem_idx),
        .mem_data (mem_data),
        .mem_mask (mem_mask),
        .do_o     (do_o),
        .do_oe    (do_oe),
        .busy_o   (busy_w),
        .wen_o    (wen_w),
        .stat_o   (stat_w),
        .rdoe_o   (rdoe_w),
        .st_o     (st_w),
        .cnt_o    (cnt_w)
    );

    mw_array #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_all  (mem_all),
        .wr_idx  (mem_idx),
        .wr_data (mem_data),
        .wr_mask (mem_mask),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_eeprom_pkg::*;
#(
    parameter int WRITE_CYCLES = 40,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             di,
    input logic             sk_rise,
    input logic             busy,
    input logic             wen,
    input logic             stat,
    input logic             rd_oe,
    input mw_state_e        st,
    input logic [CNT_W-1:0] cnt
);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs));

    // R4
    locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    // R9
    cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == '0));

    // R10
    status_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat) |-> $past(di && sk_rise && cs));

    // R11
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (st == ST_IDLE));

    // R3
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_oe, stat && cs}));
endmodule

bind mw_eeprom mw_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .di      (di),
    .sk_rise (sk_rise),
    .busy    (busy_w),
    .wen     (wen_w),
    .stat    (stat_w),
    .rd_oe   (rdoe_w),
    .st      (st_w),
    .cnt     (cnt_w)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int WC   = 40;
    localparam int AW16 = 8;
    localparam int AW8  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_x16 = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;

    always #5 clk = ~clk;

    mw_eeprom #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .org_x16(org_x16),
        .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
    );

    int n_run = 0, n_fail = 0;
    logic [15:0] mdl [128];
    bit wen_m = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b, output logic d, output logic oe);
        di = b;
        clk_n(2);
        sk = 1'b1;
        clk_n(3);
        d  = do_o;
        oe = do_oe;
        sk = 1'b0;
        clk_n(2);
    endtask

    task automatic cs_on();
        cs = 1'b1;
        clk_n(2);
    endtask

    task automatic cs_off();
        cs = 1'b0;
        di = 1'b0;
        clk_n(3);
    endtask

    function automatic int awid(bit o16);
        return o16 ? AW16 : AW8;
    endfunction

    function automatic logic [15:0] mdl_rd(bit o16, int a);
        logic [15:0] w;
        if (o16) return mdl[a & 127];
        w = mdl[(a & 255) >> 1];
        return (a & 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic mdl_wr(bit o16, int a, logic [15:0] v);
        int w;
        if (!wen_m) return;
        if (o16) mdl[a & 127] = v;
        else begin
            w = (a & 255) >> 1;
            if (a & 1) mdl[w][15:8] = v[7:0];
            else       mdl[w][7:0]  = v[7:0];
        end
    endtask

    // start bit, opcode, address, optional data, then cs low
    task automatic send_cmd(input bit o16, input logic [1:0] op, input int a,
                            input bit has_data, input logic [15:0] v, input int cut);
        logic d, oe;
        int aw = awid(o16);
        int dw = o16 ? 16 : 8;
        org_x16 = o16;
        cs_on();
        sk_bit(1'b1, d, oe);
        sk_bit(op[1], d, oe);
        sk_bit(op[0], d, oe);
        for (int i = aw - 1; i >= 0; i--) sk_bit(a[i], d, oe);
        if (has_data)
            for (int i = dw - 1; i >= cut; i--) sk_bit(v[i], d, oe);
        cs_off();
    endtask

    task automatic ext_cmd(input bit o16, input logic [1:0] top, input bit has_data, input logic [15:0] v);
        send_cmd(o16, 2'b00, int'(top) << (awid(o16) - 2), has_data, v, 0);
    endtask

    task automatic rd_chk(input bit o16, input int a, input string tag);
        logic d, oe;
        logic [15:0] v = '0;
        logic [15:0] e;
        int aw = awid(o16);
        int dw = o16 ? 16 : 8;
        org_x16 = o16;
        e = mdl_rd(o16, a);
        cs_on();
        sk_bit(1'b0, d, oe);                  // leading zero ignored (R2)
        sk_bit(1'b1, d, oe);
        sk_bit(1'b1, d, oe);
        sk_bit(1'b0, d, oe);
        for (int i = aw - 1; i >= 0; i--) sk_bit(a[i], d, oe);
        chk(oe === 1'b1 && d === 1'b0, "R3 dummy zero after address", {30'd0, oe, d}, 32'h2);
        for (int i = 0; i < dw; i++) begin
            sk_bit(1'b0, d, oe);
            v = {v[14:0], d};
        end
        chk(v === e, tag, {16'd0, v}, {16'd0, e});
        sk_bit(1'b0, d, oe);
        chk(oe === 1'b0, "R3 hi-Z after last data bit", {31'd0, oe}, 32'd0);
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (R9 cycle never ended)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic d, oe;
        int t;
        void'($urandom(32'd20231));
        for (int i = 0; i < 128; i++) mdl[i] = 16'hFFFF;
        clk_n(4);
        rst_n = 1'b1;
        clk_n(2);

        // R1 reset state
        cs = 1'b1;
        clk_n(2);
        chk(do_oe === 1'b0, "R1 do_oe low after reset", {31'd0, do_oe}, 32'd0);
        cs_off();
        rd_chk(1'b1, 0, "R1 read after reset all ones");

        // R4 locked write has no effect and starts no cycle
        send_cmd(1'b1, 2'b01, 5, 1'b1, 16'h1234, 0);
        cs_on();
        chk(do_oe === 1'b0, "R4 no status after locked write", {31'd0, do_oe}, 32'd0);
        cs_off();
        rd_chk(1'b1, 5, "R4 locked write ignored");

        // R4/R5 enable then write
        ext_cmd(1'b1, 2'b11, 1'b0, 16'h0);
        wen_m = 1;
        send_cmd(1'b1, 2'b01, 5, 1'b1, 16'hA55A, 0);
        mdl_wr(1'b1, 5, 16'hA55A);
        // R12 no drive while cs low during cycle
        chk(do_oe === 1'b0, "R12 do_oe low with cs low", {31'd0, do_oe}, 32'd0);
        cs_on();
        chk(do_oe === 1'b1 && do_o === 1'b0, "R9 busy reported", {30'd0, do_oe, do_o}, 32'h2);
        t = 0;
        while (do_o === 1'b0 && t < 200) begin
            clk_n(1);
            t++;
        end
        chk(t >= WC - 10 && t <= WC - 2, "R9 busy duration", t, WC - 5);
        chk(do_oe === 1'b1 && do_o === 1'b1, "R9 ready reported", {30'd0, do_oe, do_o}, 32'h3);
        sk_bit(1'b1, d, oe);
        chk(oe === 1'b0, "R10 dummy one releases DO when ready", {31'd0, oe}, 32'd0);
        cs_off();
        rd_chk(1'b1, 5, "R5 write word");
        rd_chk(1'b1, 5 | 128, "R2 extra address bit ignored");

        // R10 release during busy
        send_cmd(1'b1, 2'b01, 9, 1'b1, 16'h0F0F, 0);
        mdl_wr(1'b1, 9, 16'h0F0F);
        cs_on();
        chk(do_oe === 1'b1 && do_o === 1'b0, "R9 busy before release", {30'd0, do_oe, do_o}, 32'h2);
        sk_bit(1'b1, d, oe);
        chk(oe === 1'b0, "R10 dummy one releases DO while busy", {31'd0, oe}, 32'd0);
        cs_off();
        clk_n(WC + 10);
        rd_chk(1'b1, 9, "R10 write completes after release");

        // R6 erase
        send_cmd(1'b1, 2'b11, 5, 1'b0, 16'h0, 0);
        mdl_wr(1'b1, 5, 16'hFFFF);
        clk_n(WC + 10);
        rd_chk(1'b1, 5, "R6 erase word");

        // R11 aborted write
        send_cmd(1'b1, 2'b01, 9, 1'b1, 16'h1111, 6);
        cs_on();
        chk(do_oe === 1'b0, "R11 no cycle after abort", {31'd0, do_oe}, 32'd0);
        cs_off();
        clk_n(WC + 10);
        rd_chk(1'b1, 9, "R11 aborted write leaves data");

        // R8 byte mode
        send_cmd(1'b0, 2'b01, 20, 1'b1, 16'h00C3, 0);
        mdl_wr(1'b0, 20, 16'h00C3);
        clk_n(WC + 10);
        send_cmd(1'b0, 2'b01, 21, 1'b1, 16'h003C, 0);
        mdl_wr(1'b0, 21, 16'h003C);
        clk_n(WC + 10);
        rd_chk(1'b1, 10, "R8 two bytes form word");
        send_cmd(1'b0, 2'b11, 21, 1'b0, 16'h0, 0);
        mdl_wr(1'b0, 21, 16'hFFFF);
        clk_n(WC + 10);
        rd_chk(1'b0, 20, "R8 even byte kept after odd erase");
        rd_chk(1'b0, 21, "R8 odd byte erased");

        // R7 fill with data and fill with ones
        ext_cmd(1'b0, 2'b01, 1'b1, 16'h005A);
        for (int i = 0; i < 128; i++) mdl[i] = 16'h5A5A;
        clk_n(WC + 10);
        rd_chk(1'b1, 77, "R7 write-all byte mode");
        rd_chk(1'b0, 3, "R7 write-all odd byte");
        ext_cmd(1'b1, 2'b10, 1'b0, 16'h0);
        for (int i = 0; i < 128; i++) mdl[i] = 16'hFFFF;
        clk_n(WC + 10);
        rd_chk(1'b1, 77, "R7 erase-all");

        // R4 disable locks again
        ext_cmd(1'b1, 2'b00, 1'b0, 16'h0);
        wen_m = 0;
        send_cmd(1'b1, 2'b01, 40, 1'b1, 16'h7777, 0);
        clk_n(WC + 10);
        rd_chk(1'b1, 40, "R4 write after disable ignored");

        // random mix against the model
        for (int it = 0; it < 40; it++) begin
            bit o16 = 1'($urandom_range(0, 1));
            int a = int'($urandom_range(0, (1 << awid(o16)) - 1));
            logic [15:0] v = 16'($urandom());
            case ($urandom_range(0, 5))
                0, 1: rd_chk(o16, a, "R5 random read");
                2: begin
                    send_cmd(o16, 2'b01, a, 1'b1, v, 0);
                    mdl_wr(o16, a, v);
                    clk_n(WC + 10);
                    rd_chk(o16, a, "R5 random write");
                end
                3: begin
                    send_cmd(o16, 2'b11, a, 1'b0, 16'h0, 0);
                    mdl_wr(o16, a, 16'hFFFF);
                    clk_n(WC + 10);
                    rd_chk(o16, a, "R6 random erase");
                end
                4: begin
                    ext_cmd(o16, 2'b11, 1'b0, 16'h0);
                    wen_m = 1;
                end
                default: begin
                    ext_cmd(o16, 2'b00, 1'b0, 16'h0);
                    wen_m = 0;
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule